// File: doc/BRIEF.md
# Character-Cell Video Timing Generator

This block produces the raster timing for an 80-column text display in which every character cell is six pixels wide. From one pixel clock it derives three chained counters: the pixel position inside the current cell, the character column, and the line number. The default geometry has a line of 114 cells (684 pixel clocks) and a field of 263 lines. At a pixel clock near 10.74 MHz, that gives a line rate of about 15.7 kHz and a field rate of about 59.7 Hz.

The block decodes those counters into a display-enable flag, a horizontal sync and a vertical sync. A character generator and a memory fetch unit downstream use the column, pixel and line outputs to find what to draw, and use the display-enable flag to know when to draw it. Parameters set the cell width, the totals, the active area, the sync spans and the sync polarities. Character generation, memory access and colour output are handled elsewhere.

Top module: `charcell_vtiming`

## Requirements
- R1: The pixel-in-cell output advances by one on every clock with reset released. It wraps from 5 to 0.
- R2: The column output advances by one only in the clock where the pixel-in-cell output wraps. It wraps from 113 to 0, so that one line lasts exactly 684 clocks.
- R3: The line output advances by one only in the clock where the column output wraps. It wraps from 262 to 0, so that one field lasts 263 lines (179892 clocks).
- R4: Display enable is 1 exactly when the column is below 80 and the line lies in the active range 0 to 239. Each active line therefore has exactly 480 enabled pixels, and every other line has none.
- R5: Horizontal sync is at its active level exactly while the column lies in 88 to 97 (60 clocks per line). It is at its inactive level at all other times.
- R6: Vertical sync is at its active level exactly while the line lies in 243 to 245. It is at its inactive level at all other times.
- R7: While the synchronous active-low reset is sampled low, all three counters go to 0 and both syncs go to their inactive level. After reset is released, counting resumes from 0.
- R8: The sync polarity parameters (0 = active low, the default; 1 = active high) set the active level of each sync. An instance with both set to 1 drives each sync as the exact inverse of a default instance running in lockstep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| hsync_o | output | 1 | Horizontal sync, polarity set by HS_POL |
| vsync_o | output | 1 | Vertical sync, polarity set by VS_POL |
| disp_en_o | output | 1 | High in the visible area |
| cell_col_o | output | 7 | Current character column, 0 to 113 |
| cell_pix_o | output | 3 | Pixel index inside the cell, 0 to 5 |
| line_no_o | output | 9 | Current line, 0 to 262 |

## Verification
All outputs are decoded combinationally from registered counters. Every result therefore changes at the first rising edge after its cause: one edge after reset release for the first count, and one edge after reset is sampled low for the cleared state and the inactive syncs. The bench drives inputs on falling edges and samples on the next falling edge, so each result is read half a cycle after the edge that produces it. During a full-field scan it compares every clock against a model built from the elapsed clock count k: pixel = k mod 6, column = (k div 6) mod 114, and line = (k div 684) mod 263.

// File: rtl/charcell_vtiming_pkg.sv
// Package: charcell_vtiming_pkg
// Default raster geometry for the character-cell timing generator, plus a
// helper that tests whether a count falls inside a half-open span.
// Assumes all geometry values are positive and fit in 32-bit ints.
package charcell_vtiming_pkg;

    // Default horizontal geometry, counted in character cells of CELL_PIX pixels
    localparam int DEF_CELL_PIX    = 6;
    localparam int DEF_COLS_TOTAL  = 114;
    localparam int DEF_COLS_SHOWN  = 80;
    localparam int DEF_HS_COL      = 88;
    localparam int DEF_HS_COLS     = 10;

    // Default vertical geometry, counted in lines
    localparam int DEF_LINES_TOTAL = 263;
    localparam int DEF_SHOWN_FIRST = 0;
    localparam int DEF_SHOWN_LINES = 240;
    localparam int DEF_VS_LINE     = 243;
    localparam int DEF_VS_LINES    = 3;

    // Sync polarity encoding: value of the pin while sync is active
    localparam logic POL_ACTIVE_LOW  = 1'b0;
    localparam logic POL_ACTIVE_HIGH = 1'b1;

    // True when value lies in [first, first+len)
    function automatic logic in_span(input int value, input int first, input int len);
        return (value >= first) && (value < first + len);
    endfunction

endpackage

// File: rtl/charcell_wrap_ctr.sv
// Module: charcell_wrap_ctr
// Modulo-MODULUS counter that advances on step_i and flags the step on
// which it returns to zero. Three of these are chained to form the pixel,
// column and line counters of the raster.
// Assumes MODULUS >= 2 and W wide enough to hold MODULUS-1.
module charcell_wrap_ctr #(
    parameter int MODULUS = 6,
    parameter int W       = $clog2(MODULUS)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step_i,
    output logic [W-1:0] cnt_o,
    output logic         wrap_o
);

    localparam logic [W-1:0] LAST = W'(MODULUS - 1);

    logic [W-1:0] cnt_q;
    logic         at_last;

    // Detect the terminal count
    always_comb begin
        at_last = (cnt_q == LAST);
    end

    // Advance, wrap, or clear the count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (step_i) begin
            if (at_last) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // Drive outputs from the register and the carry term
    always_comb begin
        cnt_o  = cnt_q;
        wrap_o = step_i && at_last;
    end

    // R1 R2 R3: the count never leaves its range
    assert_in_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_o <= LAST)
        else $error("counter out of range");

    // R1 R2 R3: stepping at the terminal count returns to zero
    assert_wrap_to_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && cnt_o == LAST) |=> (cnt_o == '0))
        else $error("counter did not wrap");

    // R1 R2 R3: with no step the count holds
    assert_hold_without_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_i) |=> $stable(cnt_o))
        else $error("counter moved without a step");

    // R1 R2 R3: a step below the terminal count adds exactly one
    assert_step_adds_one_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && cnt_o != LAST) |=> (cnt_o == $past(cnt_o) + 1'b1))
        else $error("counter skipped");

endmodule

// File: rtl/charcell_span_sync.sv
// Module: charcell_span_sync
// Turns a raster count into a sync pin that sits at ACTIVE_LVL while the
// count lies in [FIRST, FIRST+LEN) and at the opposite level otherwise.
// Used once for the horizontal sync (column count) and once for the vertical
// sync (line count). Assumes FIRST+LEN fits in W+1 bits.
module charcell_span_sync #(
    parameter int   W          = 7,
    parameter int   FIRST      = 88,
    parameter int   LEN        = 10,
    parameter logic ACTIVE_LVL = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] cnt_i,
    output logic         sync_o
);

    localparam logic [W:0] LO = (W+1)'(FIRST);
    localparam logic [W:0] HI = (W+1)'(FIRST + LEN);

    logic hit;

    // Decide whether the count lies inside the sync span
    always_comb begin
        hit = ({1'b0, cnt_i} >= LO) && ({1'b0, cnt_i} < HI);
    end

    // Map the span onto the requested pin polarity
    always_comb begin
        sync_o = hit ? ACTIVE_LVL : ~ACTIVE_LVL;
    end

    // R5 R6: the pin sits at the active level only inside the span
    assert_sync_only_in_span_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_o == ACTIVE_LVL) |-> ({1'b0, cnt_i} >= LO && {1'b0, cnt_i} < HI))
        else $error("sync active outside its span");

    // R6: the pin does not change while the count holds still
    assert_sync_follows_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(cnt_i) |-> $stable(sync_o))
        else $error("sync changed with a steady count");

endmodule

// File: rtl/charcell_enable.sv
// Module: charcell_enable
// Marks the visible area: the column is below COLS_SHOWN and the line lies
// in [FIRST_LINE, FIRST_LINE+LINES). Assumes the active area lies inside
// the totals.
module charcell_enable #(
    parameter int COL_W      = 7,
    parameter int LINE_W     = 9,
    parameter int COLS_SHOWN = 80,
    parameter int FIRST_LINE = 0,
    parameter int LINES      = 240
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [COL_W-1:0]  col_i,
    input  logic [LINE_W-1:0] line_i,
    output logic              en_o
);

    localparam logic [COL_W:0]  COL_END  = (COL_W+1)'(COLS_SHOWN);
    localparam logic [LINE_W:0] LINE_LO  = (LINE_W+1)'(FIRST_LINE);
    localparam logic [LINE_W:0] LINE_HI  = (LINE_W+1)'(FIRST_LINE + LINES);

    logic col_ok;
    logic line_ok;

    // Horizontal part of the visible window
    always_comb begin
        col_ok = ({1'b0, col_i} < COL_END);
    end

    // Vertical part of the visible window
    always_comb begin
        line_ok = ({1'b0, line_i} >= LINE_LO) && ({1'b0, line_i} < LINE_HI);
    end

    // Combine both parts of the window
    always_comb begin
        en_o = col_ok && line_ok;
    end

    // R4: display enable never shows in the horizontal border
    assert_en_column_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        en_o |-> ({1'b0, col_i} < COL_END))
        else $error("enable outside active columns");

    // R4: display enable never shows outside the active lines
    assert_en_line_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        en_o |-> ({1'b0, line_i} >= LINE_LO && {1'b0, line_i} < LINE_HI))
        else $error("enable outside active lines");

endmodule

// File: rtl/charcell_vtiming.sv
// Module: charcell_vtiming
// Raster timing for a character-cell text display on one pixel clock.
// A pixel-in-cell counter carries into a column counter, which carries into
// a line counter; display enable and both syncs are decoded from those
// registers with no extra latency. Assumes the sync spans lie inside the
// blanking regions and that all spans fit inside the totals.
module charcell_vtiming
    import charcell_vtiming_pkg::*;
#(
    parameter int   CELL_PIX    = DEF_CELL_PIX,
    parameter int   COLS_TOTAL  = DEF_COLS_TOTAL,
    parameter int   COLS_SHOWN  = DEF_COLS_SHOWN,
    parameter int   HS_COL      = DEF_HS_COL,
    parameter int   HS_COLS     = DEF_HS_COLS,
    parameter int   LINES_TOTAL = DEF_LINES_TOTAL,
    parameter int   SHOWN_FIRST = DEF_SHOWN_FIRST,
    parameter int   SHOWN_LINES = DEF_SHOWN_LINES,
    parameter int   VS_LINE     = DEF_VS_LINE,
    parameter int   VS_LINES    = DEF_VS_LINES,
    parameter logic HS_POL      = POL_ACTIVE_LOW,
    parameter logic VS_POL      = POL_ACTIVE_LOW,
    localparam int  PIX_W       = $clog2(CELL_PIX),
    localparam int  COL_W       = $clog2(COLS_TOTAL),
    localparam int  LINE_W      = $clog2(LINES_TOTAL)
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              hsync_o,
    output logic              vsync_o,
    output logic              disp_en_o,
    output logic [COL_W-1:0]  cell_col_o,
    output logic [PIX_W-1:0]  cell_pix_o,
    output logic [LINE_W-1:0] line_no_o
);

    logic [PIX_W-1:0]  pix;
    logic [COL_W-1:0]  col;
    logic [LINE_W-1:0] line;
    logic              cell_end;
    logic              line_end;
    logic              field_end;

    // Pixel position inside the current character cell
    charcell_wrap_ctr #(.MODULUS(CELL_PIX), .W(PIX_W)) u_pix_ctr (
        .clk    (clk),
        .rst_n  (rst_n),
        .step_i (1'b1),
        .cnt_o  (pix),
        .wrap_o (cell_end)
    );

    // Character column, advanced once per cell
    charcell_wrap_ctr #(.MODULUS(COLS_TOTAL), .W(COL_W)) u_col_ctr (
        .clk    (clk),
        .rst_n  (rst_n),
        .step_i (cell_end),
        .cnt_o  (col),
        .wrap_o (line_end)
    );

    // Line number, advanced once per full line
    charcell_wrap_ctr #(.MODULUS(LINES_TOTAL), .W(LINE_W)) u_line_ctr (
        .clk    (clk),
        .rst_n  (rst_n),
        .step_i (line_end),
        .cnt_o  (line),
        .wrap_o (field_end)
    );

    // Horizontal sync across a span of columns
    charcell_span_sync #(.W(COL_W), .FIRST(HS_COL), .LEN(HS_COLS), .ACTIVE_LVL(HS_POL)) u_hsync (
        .clk    (clk),
        .rst_n  (rst_n),
        .cnt_i  (col),
        .sync_o (hsync_o)
    );

    // Vertical sync across a span of lines
    charcell_span_sync #(.W(LINE_W), .FIRST(VS_LINE), .LEN(VS_LINES), .ACTIVE_LVL(VS_POL)) u_vsync (
        .clk    (clk),
        .rst_n  (rst_n),
        .cnt_i  (line),
        .sync_o (vsync_o)
    );

    // Visible-area flag
    charcell_enable #(
        .COL_W      (COL_W),
        .LINE_W     (LINE_W),
        .COLS_SHOWN (COLS_SHOWN),
        .FIRST_LINE (SHOWN_FIRST),
        .LINES      (SHOWN_LINES)
    ) u_enable (
        .clk    (clk),
        .rst_n  (rst_n),
        .col_i  (col),
        .line_i (line),
        .en_o   (disp_en_o)
    );

    // Bring the raster position out
    always_comb begin
        cell_pix_o = pix;
        cell_col_o = col;
        line_no_o  = line;
    end

    // R7: the first cycle after reset release starts at the origin, syncs idle
    assert_reset_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pix == '0 && col == '0 && line == '0
                          && hsync_o == ~HS_POL && vsync_o == ~VS_POL))
        else $error("reset did not clear the raster");

    // R4 R5: the picture is blanked while horizontal sync is active
    assert_blank_in_hsync_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (hsync_o == HS_POL) |-> !disp_en_o)
        else $error("enable during horizontal sync");

    // R4 R6: the picture is blanked while vertical sync is active
    assert_blank_in_vsync_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (vsync_o == VS_POL) |-> !disp_en_o)
        else $error("enable during vertical sync");

    // R3: a field ends only at the end of a line
    assert_field_on_line_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
        field_end |-> (line_end && cell_end))
        else $error("field ended mid-line");

    // R2: the column moves only when a cell completes
    assert_col_needs_cell_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (col != $past(col)) |-> $past(cell_end))
        else $error("column moved mid-cell");

endmodule

// File: tb/charcell_vtiming_tb.sv
// Directed bench for charcell_vtiming: reset state, a full-field scan
// against a model computed from the elapsed clock count, and a mid-line reset.
module charcell_vtiming_tb_top;

    localparam int CELL   = 6;
    localparam int COLS   = 114;
    localparam int LINES  = 263;
    localparam int LINE_CLK  = CELL * COLS;
    localparam int FIELD_CLK = LINE_CLK * LINES;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hs, vs, de;
    logic [6:0] col;
    logic [2:0] pix;
    logic [8:0] line;
    logic       hs_p, vs_p, de_p;
    logic [6:0] col_p;
    logic [2:0] pix_p;
    logic [8:0] line_p;

    int tests_run = 0;
    int tests_failed = 0;

    always #4 clk = ~clk;

    charcell_vtiming dut_i (
        .clk(clk), .rst_n(rst_n), .hsync_o(hs), .vsync_o(vs), .disp_en_o(de),
        .cell_col_o(col), .cell_pix_o(pix), .line_no_o(line)
    );

    charcell_vtiming #(.HS_POL(1'b1), .VS_POL(1'b1)) dut_pos_i (
        .clk(clk), .rst_n(rst_n), .hsync_o(hs_p), .vsync_o(vs_p), .disp_en_o(de_p),
        .cell_col_o(col_p), .cell_pix_o(pix_p), .line_no_o(line_p)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        tests_run++;
        if (!ok) begin
            tests_failed++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic summary_and_end();
        $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    endtask

    // R7: held in reset, counters are zero and syncs idle
    task automatic t_reset_state();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(pix == 0,  "R7", "pix in reset",  int'(pix), 0);
        check(col == 0,  "R7", "col in reset",  int'(col), 0);
        check(line == 0, "R7", "line in reset", int'(line), 0);
        check(hs == 1'b1 && vs == 1'b1, "R7", "syncs idle (low pol)", int'({hs, vs}), 3);
        check(hs_p == 1'b0 && vs_p == 1'b0, "R8", "syncs idle (high pol)", int'({hs_p, vs_p}), 0);
    endtask

    // R1..R6, R8: every clock of one field against the count model
    task automatic t_field_scan();
        int bad_pix = 0, bad_col = 0, bad_line = 0, bad_de = 0;
        int bad_hs = 0, bad_vs = 0, bad_pol = 0;
        int de_cnt[LINES];
        int hs_cnt[LINES];
        int bad_de_lines = 0, bad_hs_lines = 0;
        int first_bad_de = 0;
        for (int l = 0; l < LINES; l++) begin
            de_cnt[l] = 0;
            hs_cnt[l] = 0;
        end
        rst_n = 1'b1;
        for (int k = 0; k < FIELD_CLK; k++) begin
            int ep = k % CELL;
            int ec = (k / CELL) % COLS;
            int el = k / LINE_CLK;
            bit e_de = (ec < 80) && (el < 240);
            bit e_hs = !((ec >= 88) && (ec < 98));
            bit e_vs = !((el >= 243) && (el < 246));
            if (int'(pix) != ep)  bad_pix++;
            if (int'(col) != ec)  bad_col++;
            if (int'(line) != el) bad_line++;
            if (de != e_de) bad_de++;
            if (hs != e_hs) bad_hs++;
            if (vs != e_vs) bad_vs++;
            if (hs_p != ~hs || vs_p != ~vs || de_p != de) bad_pol++;
            if (de) de_cnt[el]++;
            if (!hs) hs_cnt[el]++;
            @(negedge clk);
        end
        check(bad_pix == 0,  "R1", "pixel mismatches", bad_pix, 0);
        check(bad_col == 0,  "R2", "column mismatches", bad_col, 0);
        check(bad_line == 0, "R3", "line mismatches", bad_line, 0);
        check(bad_de == 0,   "R4", "enable mismatches", bad_de, 0);
        for (int l = 0; l < LINES; l++) begin
            int want = (l < 240) ? 480 : 0;
            if (de_cnt[l] != want) begin
                if (bad_de_lines == 0) first_bad_de = de_cnt[l];
                bad_de_lines++;
            end
            if (hs_cnt[l] != 60) bad_hs_lines++;
        end
        check(bad_de_lines == 0, "R4", "lines without 480 enabled pixels", bad_de_lines, 0);
        check(de_cnt[0] == 480,  "R4", "enabled pixels on line 0", de_cnt[0], 480);
        check(de_cnt[240] == 0,  "R4", "enabled pixels on line 240", de_cnt[240], 0);
        check(bad_hs == 0,       "R5", "hsync mismatches", bad_hs, 0);
        check(bad_hs_lines == 0, "R5", "lines without 60 hsync clocks", bad_hs_lines, 0);
        check(bad_vs == 0,       "R6", "vsync mismatches", bad_vs, 0);
        check(bad_pol == 0,      "R8", "polarity mismatches", bad_pol, 0);
        // after exactly 684*263 clocks the raster is back at the origin
        check(pix == 0 && col == 0 && line == 0, "R3", "field wrap to origin",
              int'(line), 0);
        if (first_bad_de != 0) $display("note: first bad line enable count %0d", first_bad_de);
    endtask

    // R7: reset taken during horizontal sync clears at the next edge
    task automatic t_mid_reset();
        repeat (90 * CELL) @(negedge clk);
        check(col == 90 && hs == 1'b0, "R5", "in hsync at column 90", int'(col), 90);
        rst_n = 1'b0;
        @(negedge clk);
        check(col == 0 && pix == 0 && line == 0, "R7", "cleared after one edge",
              int'(col), 0);
        check(hs == 1'b1 && hs_p == 1'b0, "R7", "hsync idle after reset",
              int'({hs, hs_p}), 2);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        repeat (7) @(negedge clk);
        check(pix == 1 && col == 1 && line == 0, "R7", "resumed count after release",
              int'(pix), 1);
    endtask

    initial begin
        repeat (198000) @(posedge clk);
        tests_run++;
        tests_failed++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary_and_end();
    end

    initial begin
        t_reset_state();
        t_field_scan();
        t_mid_reset();
        summary_and_end();
    end

endmodule